// File: doc/BRIEF.md
# Serial Flash Identity Reader

This block asks a serial NOR flash who made it. On a start pulse it selects the flash and sends the read-identity command byte 0x9F. It then reads bytes back until it finds the manufacturer code. Each 0x7F byte read in that position is a continuation marker: it moves the manufacturer bank up by one and is thrown away. The first byte that is not 0x7F is the manufacturer code, and it must have odd parity. A valid code is followed by exactly two device-identity bytes. After the last byte, chip select is released and a one-cycle done pulse reports success or failure.

The bit shifting on the SPI wires is done by a separate byte-transfer engine. This block hands that engine one byte at a time through a request/acknowledge pair. The request stays high, with its transmit byte steady, until the engine acknowledges; the received byte is valid in the acknowledge cycle. With the request still high in the next cycle, the next byte starts at once. The identity result registers change only when a read succeeds, so a failed read leaves the last good identity readable.

Top module: `flash_id_reader`

## Requirements
- R1: A start pulse accepted while idle drives `spi_cs_n` low and requests a first byte with `xfer_tx` = 0x9F. `spi_cs_n` stays low until the exchange ends, and `xfer_req` is high only while `spi_cs_n` is low.
- R2: The bank begins at 1 and goes up by 1 for each received 0x7F in the manufacturer position. Each such byte is discarded and another byte is read.
- R3: A manufacturer byte other than 0x7F with an even number of one bits ends the exchange with `id_err` = 1. No device byte is read and `spi_cs_n` returns high.
- R4: After a valid manufacturer byte, exactly two more bytes are read. The first goes to `id_device[15:8]` and the second to `id_device[7:0]`; 0x7F has no special meaning there. `spi_cs_n` returns high after the second byte.
- R5: `id_bank`, `id_manuf` and `id_device` are updated only by a successful exchange. A failed exchange leaves them unchanged. All three are 0 after reset.
- R6: At most MAX_CONT continuation bytes (16 by default) are accepted, so the bank can reach MAX_CONT+1. A further 0x7F ends the exchange with `id_err` = 1.
- R7: Every byte after the command byte is sent with `xfer_tx` = 0x00.
- R8: A start pulse while an exchange is in progress has no effect: no extra byte is requested and no extra done pulse appears.
- R9: `id_done` is a single-cycle pulse in the cycle the final status appears. `id_err` holds that status (1 for failure, 0 for success) until the next accepted start clears it.
- R10: A byte completes only in a cycle where `xfer_req` and `xfer_ack` are both high. While the request waits, `xfer_req` stays high and `xfer_tx` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an identity read (used only when idle) |
| xfer_req | output | 1 | Byte transfer request to the byte engine |
| xfer_tx | output | 8 | Byte to transmit for the current request |
| xfer_ack | input | 1 | Byte engine has completed the requested byte |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |
| spi_cs_n | output | 1 | Flash chip select, active low |
| id_done | output | 1 | One-cycle completion pulse |
| id_err | output | 1 | Status of the last exchange (1 = failed) |
| id_bank | output | BANK_W | Manufacturer bank number (5 bits by default) |
| id_manuf | output | 8 | Manufacturer code |
| id_device | output | 16 | Device identity, first byte in the upper half |

## Verification
The bench covers several bank depths: no continuation, two continuations, and exactly the cap. It checks that the cap of MAX_CONT continuations is accepted and that one more is rejected. An off-by-one cap would either wrongly fail the full-depth part or read one byte too many. A parity error follows a continuation byte, and the case uses byte values that a design checking even parity instead of odd would accept. Device bytes equal to 0x7F and 0x00 check that the continuation rule applies only to the manufacturer position. A design that leaked the rule into the device bytes would read extra bytes and report the wrong bank. After each failure the bench confirms the previous identity is still on the outputs, and it pulses start in the middle of an exchange. A design that restarted on that pulse would send a second 0x9F and pulse done twice.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;

    localparam logic [7:0] CMD_READ_ID = 8'h9F;
    localparam logic [7:0] CONT_CODE   = 8'h7F;
    localparam logic [7:0] FILL_BYTE   = 8'h00;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_MANUF,
        PH_DEV_HI,
        PH_DEV_LO
    } phase_t;

    typedef enum logic [1:0] {
        MB_GOOD,
        MB_CONT,
        MB_PARITY,
        MB_OVERRUN
    } mbyte_t;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } dev_id_t;

    function automatic logic has_odd_parity(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/flash_id_collect.sv
module flash_id_collect
    import flash_id_pkg::*;
#(
    parameter int MAX_CONT = 16,
    parameter int BANK_W   = $clog2(MAX_CONT + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_t            phase,
    input  logic              byte_done,
    input  logic [7:0]        rx,
    output mbyte_t            mclass,
    output logic [BANK_W-1:0] id_bank,
    output logic [7:0]        id_manuf,
    output logic [15:0]       id_device
);

    localparam logic [BANK_W-1:0] BANK_FIRST = BANK_W'(1);
    localparam logic [BANK_W-1:0] BANK_LIMIT = BANK_W'(MAX_CONT + 1);

    logic [BANK_W-1:0] bank_q;
    logic [7:0]        manuf_q;
    logic [7:0]        hi_q;
    dev_id_t           dev_next;

    always_comb begin
        if (rx == CONT_CODE) begin
            mclass = (bank_q == BANK_LIMIT) ? MB_OVERRUN : MB_CONT;
        end else if (has_odd_parity(rx)) begin
            mclass = MB_GOOD;
        end else begin
            mclass = MB_PARITY;
        end
    end

    always_comb begin
        dev_next.hi = hi_q;
        dev_next.lo = rx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q    <= '0;
            manuf_q   <= '0;
            hi_q      <= '0;
            id_bank   <= '0;
            id_manuf  <= '0;
            id_device <= '0;
        end else if (byte_done) begin
            case (phase)
                PH_CMD: bank_q <= BANK_FIRST;
                PH_MANUF: begin
                    if (mclass == MB_CONT) begin
                        bank_q <= bank_q + BANK_FIRST;
                    end else if (mclass == MB_GOOD) begin
                        manuf_q <= rx;
                    end
                end
                PH_DEV_HI: hi_q <= rx;
                PH_DEV_LO: begin
                    id_bank   <= bank_q;
                    id_manuf  <= manuf_q;
                    id_device <= dev_next;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/flash_id_sequencer.sv
module flash_id_sequencer
    import flash_id_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       xfer_ack,
    input  mbyte_t     mclass,
    output phase_t     phase,
    output logic       byte_done,
    output logic       xfer_req,
    output logic [7:0] xfer_tx,
    output logic       spi_cs_n,
    output logic       id_done,
    output logic       id_err
);

    assign byte_done = xfer_req & xfer_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            xfer_req <= 1'b0;
            xfer_tx  <= FILL_BYTE;
            spi_cs_n <= 1'b1;
            id_done  <= 1'b0;
            id_err   <= 1'b0;
        end else begin
            id_done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_CMD;
                        xfer_req <= 1'b1;
                        xfer_tx  <= CMD_READ_ID;
                        spi_cs_n <= 1'b0;
                        id_err   <= 1'b0;
                    end
                end
                PH_CMD: begin
                    if (byte_done) begin
                        phase   <= PH_MANUF;
                        xfer_tx <= FILL_BYTE;
                    end
                end
                PH_MANUF: begin
                    if (byte_done) begin
                        case (mclass)
                            MB_GOOD: phase <= PH_DEV_HI;
                            MB_CONT: phase <= PH_MANUF;
                            default: begin
                                phase    <= PH_IDLE;
                                xfer_req <= 1'b0;
                                spi_cs_n <= 1'b1;
                                id_done  <= 1'b1;
                                id_err   <= 1'b1;
                            end
                        endcase
                    end
                end
                PH_DEV_HI: begin
                    if (byte_done) begin
                        phase <= PH_DEV_LO;
                    end
                end
                PH_DEV_LO: begin
                    if (byte_done) begin
                        phase    <= PH_IDLE;
                        xfer_req <= 1'b0;
                        spi_cs_n <= 1'b1;
                        id_done  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_id_reader.sv
module flash_id_reader
    import flash_id_pkg::*;
#(
    parameter int MAX_CONT = 16,
    parameter int BANK_W   = $clog2(MAX_CONT + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              xfer_req,
    output logic [7:0]        xfer_tx,
    input  logic              xfer_ack,
    input  logic [7:0]        xfer_rx,
    output logic              spi_cs_n,
    output logic              id_done,
    output logic              id_err,
    output logic [BANK_W-1:0] id_bank,
    output logic [7:0]        id_manuf,
    output logic [15:0]       id_device
);

    phase_t phase;
    mbyte_t mclass;
    logic   byte_done;

    flash_id_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .xfer_ack  (xfer_ack),
        .mclass    (mclass),
        .phase     (phase),
        .byte_done (byte_done),
        .xfer_req  (xfer_req),
        .xfer_tx   (xfer_tx),
        .spi_cs_n  (spi_cs_n),
        .id_done   (id_done),
        .id_err    (id_err)
    );

    flash_id_collect #(
        .MAX_CONT (MAX_CONT),
        .BANK_W   (BANK_W)
    ) u_collect (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .byte_done (byte_done),
        .rx        (xfer_rx),
        .mclass    (mclass),
        .id_bank   (id_bank),
        .id_manuf  (id_manuf),
        .id_device (id_device)
    );

endmodule

// File: rtl/flash_id_checker.sv
module flash_id_checker #(
    parameter int MAX_CONT = 16,
    parameter int BANK_W   = $clog2(MAX_CONT + 2)
) (
    input logic              clk,
    input logic              rst,
    input logic              xfer_req,
    input logic [7:0]        xfer_tx,
    input logic              xfer_ack,
    input logic              spi_cs_n,
    input logic              id_done,
    input logic              id_err,
    input logic [BANK_W-1:0] id_bank,
    input logic [7:0]        id_manuf,
    input logic [15:0]       id_device
);

    assert_req_under_cs_R1: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> !spi_cs_n);

    assert_first_byte_cmd_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_req) |-> xfer_tx == 8'h9F);

    assert_manuf_odd_R3: assert property (@(posedge clk) disable iff (rst)
        (id_done && !id_err) |-> (^id_manuf));

    assert_release_at_end_R4: assert property (@(posedge clk) disable iff (rst)
        id_done |-> (spi_cs_n && !xfer_req));

    assert_ids_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(id_done && !id_err) |-> $stable({id_bank, id_manuf, id_device}));

    assert_bank_range_R6: assert property (@(posedge clk) disable iff (rst)
        (id_done && !id_err) |-> (id_bank != '0 && int'(id_bank) <= MAX_CONT + 1));

    assert_fill_after_cmd_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(xfer_req && xfer_ack) && xfer_req) |-> xfer_tx == 8'h00);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        id_done |=> !id_done);

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(id_err) |-> id_done);

    assert_req_waits_R10: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

endmodule

bind flash_id_reader flash_id_checker #(
    .MAX_CONT (MAX_CONT),
    .BANK_W   (BANK_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .xfer_req  (xfer_req),
    .xfer_tx   (xfer_tx),
    .xfer_ack  (xfer_ack),
    .spi_cs_n  (spi_cs_n),
    .id_done   (id_done),
    .id_err    (id_err),
    .id_bank   (id_bank),
    .id_manuf  (id_manuf),
    .id_device (id_device)
);

// File: tb/tb_flash_id_reader.sv
module tb_flash_id_reader;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CONT   = 16;
    localparam int BANK_W     = $clog2(MAX_CONT + 2);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              xfer_req;
    logic [7:0]        xfer_tx;
    logic              xfer_ack = 1'b0;
    logic [7:0]        xfer_rx = 8'h00;
    logic              spi_cs_n;
    logic              id_done;
    logic              id_err;
    logic [BANK_W-1:0] id_bank;
    logic [7:0]        id_manuf;
    logic [15:0]       id_device;

    flash_id_reader #(.MAX_CONT(MAX_CONT)) dut (
        .clk(clk), .rst(rst), .start(start),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
        .spi_cs_n(spi_cs_n), .id_done(id_done), .id_err(id_err),
        .id_bank(id_bank), .id_manuf(id_manuf), .id_device(id_device)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 1'b0;

    // reference state
    logic [7:0]        flash_q[$];
    logic [7:0]        rx_q[$];
    logic [7:0]        tx_log[$];
    int                resp_lat = 0;
    logic [BANK_W-1:0] ref_bank = '0;
    logic [7:0]        ref_manuf = '0;
    logic [15:0]       ref_dev = '0;
    logic [BANK_W-1:0] exp_bank;
    logic [7:0]        exp_manuf;
    logic [15:0]       exp_dev;
    bit                exp_err;
    bit                monitor_on = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // byte engine model
    initial begin : responder
        int wait_c;
        wait_c = 0;
        forever begin
            @(negedge clk);
            xfer_ack = 1'b0;
            if (xfer_req) begin
                if (wait_c >= resp_lat) begin
                    xfer_ack = 1'b1;
                    xfer_rx  = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hFF;
                    tx_log.push_back(xfer_tx);
                    wait_c = 0;
                end else begin
                    wait_c++;
                end
            end else begin
                wait_c = 0;
            end
        end
    end

    // per-clock comparison against the reference model
    initial begin : monitor
        forever begin
            @(negedge clk);
            if (monitor_on) begin
                if (id_done && !exp_err) begin
                    ref_bank  = exp_bank;
                    ref_manuf = exp_manuf;
                    ref_dev   = exp_dev;
                end
                check(id_bank == ref_bank, "R5", "bank vs model", int'(id_bank), int'(ref_bank));
                check(id_manuf == ref_manuf, "R5", "manuf vs model", int'(id_manuf), int'(ref_manuf));
                check(id_device == ref_dev, "R5", "device vs model", int'(id_device), int'(ref_dev));
                check(!(xfer_req && spi_cs_n), "R1", "req outside chip select", int'(spi_cs_n), 0);
            end
        end
    end

    // run one exchange; flash_q holds the bytes the flash returns after the command
    task automatic run_case(input string name, input int lat, input bit poke, input string req);
        int idx;
        int nbytes;
        int bank;
        int cyc;
        bit seen;
        logic [7:0] b;
        // expected result
        exp_err = 1'b0; bank = 1; idx = 0; nbytes = 1;
        exp_manuf = 8'h00; exp_dev = 16'h0000;
        forever begin
            b = flash_q[idx]; idx++; nbytes++;
            if (b == 8'h7F) begin
                if (bank == MAX_CONT + 1) begin exp_err = 1'b1; break; end
                bank++;
                continue;
            end
            if (^b == 1'b0) begin exp_err = 1'b1; break; end
            exp_manuf = b;
            exp_dev = {flash_q[idx], flash_q[idx+1]};
            nbytes += 2;
            break;
        end
        exp_bank = BANK_W'(bank);
        rx_q.delete(); tx_log.delete();
        rx_q.push_back(8'hFF);
        foreach (flash_q[i]) rx_q.push_back(flash_q[i]);
        resp_lat = lat;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(!spi_cs_n, "R1", {name, " cs low after start"}, int'(spi_cs_n), 0);
        if (poke) begin
            repeat (2) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        seen = 1'b0; cyc = 0;
        while (!seen && cyc < 2000) begin
            if (id_done) seen = 1'b1;
            else begin @(negedge clk); cyc++; end
        end
        check(seen, "R9", {name, " done seen"}, int'(seen), 1);
        check(id_err == exp_err, exp_err ? (bank > MAX_CONT ? "R6" : "R3") : "R4",
              {name, " status"}, int'(id_err), int'(exp_err));
        check(tx_log.size() == nbytes, poke ? "R8" : "R2", {name, " byte count"},
              tx_log.size(), nbytes);
        foreach (tx_log[i]) begin
            if (i == 0) check(tx_log[i] == 8'h9F, "R1", {name, " command byte"}, int'(tx_log[i]), 'h9F);
            else check(tx_log[i] == 8'h00, "R7", {name, " fill byte"}, int'(tx_log[i]), 0);
        end
        check(spi_cs_n && !xfer_req, "R4", {name, " released"}, int'(spi_cs_n), 1);
        @(negedge clk);
        check(!id_done, "R9", {name, " done one cycle"}, int'(id_done), 0);
        check(id_err == exp_err, "R9", {name, " status held"}, int'(id_err), int'(exp_err));
        repeat (3) @(negedge clk);
        check(!id_done && spi_cs_n, req, {name, " quiet after"}, int'(id_done), 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            tests_run++; tests_failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R5, R9)
        check(spi_cs_n == 1'b1 && xfer_req == 1'b0, "R1", "reset idle bus", int'(spi_cs_n), 1);
        check(!id_done && !id_err, "R9", "reset status", int'(id_err), 0);
        check(id_bank == '0 && id_manuf == '0 && id_device == '0, "R5", "reset ids",
              int'(id_manuf), 0);
        monitor_on = 1'b1;

        // bank 1, no continuation
        flash_q = '{8'h20, 8'h71, 8'h18};
        run_case("bank1", 0, 1'b0, "R4");
        check(id_bank == 1 && id_manuf == 8'h20 && id_device == 16'h7118, "R2", "bank1 ids",
              int'(id_device), 'h7118);

        // two continuations, slow engine
        flash_q = '{8'h7F, 8'h7F, 8'hC2, 8'h20, 8'h16};
        run_case("bank3", 2, 1'b0, "R2");
        check(id_bank == 3 && id_manuf == 8'hC2, "R2", "bank3 ids", int'(id_bank), 3);

        // even parity after a continuation
        flash_q = '{8'h7F, 8'h03, 8'h55, 8'h55};
        run_case("parity", 1, 1'b0, "R3");
        check(id_bank == 3 && id_device == 16'h2016, "R5", "ids kept after parity fail",
              int'(id_device), 'h2016);

        // exactly the cap, then good
        flash_q.delete();
        for (int i = 0; i < MAX_CONT; i++) flash_q.push_back(8'h7F);
        flash_q.push_back(8'h01); flash_q.push_back(8'hAB); flash_q.push_back(8'hCD);
        run_case("cap_ok", 0, 1'b0, "R6");
        check(id_bank == MAX_CONT + 1, "R6", "bank at cap", int'(id_bank), MAX_CONT + 1);

        // one beyond the cap
        flash_q.delete();
        for (int i = 0; i < MAX_CONT + 2; i++) flash_q.push_back(8'h7F);
        run_case("cap_over", 0, 1'b0, "R6");
        check(id_manuf == 8'h01 && id_device == 16'hABCD, "R5", "ids kept after overrun",
              int'(id_device), 'hABCD);

        // device bytes equal to 0x7F and 0x00, start pulse mid-exchange
        flash_q = '{8'h80, 8'h7F, 8'h00};
        run_case("busy_start", 1, 1'b1, "R8");
        check(id_bank == 1 && id_device == 16'h7F00, "R4", "device 7F not continuation",
              int'(id_device), 'h7F00);

        // even-parity 0xFF after success, then success clears status
        flash_q = '{8'hFF};
        run_case("parity_ff", 0, 1'b0, "R3");
        flash_q = '{8'h0E, 8'h12, 8'h34};
        run_case("recover", 3, 1'b0, "R9");
        check(!id_err && id_manuf == 8'h0E, "R9", "status cleared", int'(id_err), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule